// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block performs the state transition a 32-bit core makes when it takes an interrupt or a general (non-reset) exception. At each instruction boundary it looks at a pending interrupt request and a pending general exception request. It picks at most one of them. It then snapshots the program counter and status word, and produces the privileged-mode status word for the handler. It records a 12-bit event code and computes the handler address from the vector base.

The surrounding pipeline owns the real status register and program counter. It loads `newSr` when `redirect` pulses and fetches from `target`. Interrupt requests blocked by the block bit are not latched here. The requester keeps them asserted until a later boundary accepts them.

Top module: `exc_entry_top`

## Requirements
- R1: A request is accepted only in a cycle where `boundary` is 1. Without it, `redirect` stays 0 and no saved or event register changes.
- R2: On acceptance, `savedPc` and `savedSr` take the values `curPc` and `curSr` had in the accepting cycle, before any status bit is modified.
- R3: On acceptance, `newSr` equals `curSr` with the block bit (bit 28), the bank bit (bit 29) and the privilege bit (bit 30) forced to 1, and all other bits unchanged.
- R4: An accepted interrupt writes `intCode` into bits 11:0 of both `intEvt` and `intEvt2`. Bits 31:12 of every event register always read 0.
- R5: An accepted general exception writes `excCode` into bits 11:0 of `expEvt` and leaves `intEvt` and `intEvt2` unchanged.
- R6: The target is `vecBase` + 0x600 for an interrupt, `vecBase` + 0x400 for a general exception with `excTlbMiss` = 1, and `vecBase` + 0x100 for any other general exception.
- R7: An interrupt request is ignored while `curSr` bit 28 is 1. In that case there is no redirect and no register change. General exceptions are accepted regardless of that bit.
- R8: When both requests are present at the same boundary, the general exception is taken and the interrupt is ignored.
- R9: All updates and the `redirect` pulse appear together, one clock after the accepting cycle. `redirect` is 1 for exactly the cycles that follow an acceptance.
- R10: A synchronous active-high `rst` clears the saved registers, `newSr`, the event registers, `target` and `redirect` on the next clock edge.
- R11: The target addition wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Current instruction completes this cycle |
| intReq | input | 1 | Interrupt request pending |
| intCode | input | 12 | Interrupt event code |
| excReq | input | 1 | General exception request pending |
| excCode | input | 12 | Exception event code |
| excTlbMiss | input | 1 | Exception is a translation miss |
| curPc | input | 32 | Program counter of the completing instruction stream |
| curSr | input | 32 | Current status word |
| vecBase | input | 32 | Vector base address |
| savedPc | output | 32 | Saved program counter |
| savedSr | output | 32 | Saved status word |
| newSr | output | 32 | Status word to load on entry |
| intEvt | output | 32 | Interrupt event register |
| intEvt2 | output | 32 | Second interrupt event register |
| expEvt | output | 32 | Exception event register |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| target | output | 32 | Handler address |

## Verification
The hardest case to reach from the ports is an interrupt that arrives together with an exception while the block bit is already set. Here the priority rule and the masking rule act at once, and the interrupt registers must be shown unchanged. The bench reaches it by sweeping all 32 combinations of boundary, both requests, the miss flag and status bit 28 against several data patterns. It checks after each step that the interrupt registers still hold earlier codes. Vector bases near the top of the address space cover the wrap of the target adder.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    VEC_GENERAL = 2'd0,
    VEC_TLBMISS = 2'd1,
    VEC_INTR    = 2'd2
  } vecSel_t;

  typedef struct packed {
    logic    take;
    logic    isIntr;
    vecSel_t sel;
  } entryCtl_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic      boundary,
  input  logic      intReq,
  input  logic      excReq,
  input  logic      excTlbMiss,
  input  logic      blockNow,
  output entryCtl_t ctl
);
  logic intOk;
  logic excOk;

  always_comb begin
    excOk = boundary && excReq;
    intOk = boundary && intReq && !blockNow && !excReq;
    ctl.take   = excOk || intOk;
    ctl.isIntr = intOk;
    if (intOk)           ctl.sel = VEC_INTR;
    else if (excTlbMiss) ctl.sel = VEC_TLBMISS;
    else                 ctl.sel = VEC_GENERAL;
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int EVT_W = 12,
  parameter int BL_BIT = 28,
  parameter int RB_BIT = 29,
  parameter int MD_BIT = 30,
  parameter logic [31:0] INT_OFS = 32'h0000_0600,
  parameter logic [31:0] TLB_OFS = 32'h0000_0400,
  parameter logic [31:0] GEN_OFS = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst,
  input  entryCtl_t        ctl,
  input  logic [EVT_W-1:0] intCode,
  input  logic [EVT_W-1:0] excCode,
  input  logic [XLEN-1:0]  curPc,
  input  logic [XLEN-1:0]  curSr,
  input  logic [XLEN-1:0]  vecBase,
  output logic [XLEN-1:0]  savedPc,
  output logic [XLEN-1:0]  savedSr,
  output logic [XLEN-1:0]  newSr,
  output logic [XLEN-1:0]  intEvt,
  output logic [XLEN-1:0]  intEvt2,
  output logic [XLEN-1:0]  expEvt,
  output logic             redirect,
  output logic [XLEN-1:0]  target
);
  localparam int PAD_W = XLEN - EVT_W;
  localparam logic [XLEN-1:0] SET_MASK =
    (XLEN'(1) << BL_BIT) | (XLEN'(1) << RB_BIT) | (XLEN'(1) << MD_BIT);

  logic [EVT_W-1:0] intEvtQ, intEvt2Q, expEvtQ;
  logic [XLEN-1:0]  offset;
  logic [XLEN-1:0]  sum;

  always_comb begin
    case (ctl.sel)
      VEC_INTR:    offset = XLEN'(INT_OFS);
      VEC_TLBMISS: offset = XLEN'(TLB_OFS);
      default:     offset = XLEN'(GEN_OFS);
    endcase
    sum = vecBase + offset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      savedPc  <= '0;
      savedSr  <= '0;
      newSr    <= '0;
      intEvtQ  <= '0;
      intEvt2Q <= '0;
      expEvtQ  <= '0;
      redirect <= 1'b0;
      target   <= '0;
    end else begin
      redirect <= ctl.take;
      if (ctl.take) begin
        savedPc <= curPc;
        savedSr <= curSr;
        newSr   <= curSr | SET_MASK;
        target  <= sum;
        if (ctl.isIntr) begin
          intEvtQ  <= intCode;
          intEvt2Q <= intCode;
        end else begin
          expEvtQ <= excCode;
        end
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign intEvt  = {{PAD_W{1'b0}}, intEvtQ};
      assign intEvt2 = {{PAD_W{1'b0}}, intEvt2Q};
      assign expEvt  = {{PAD_W{1'b0}}, expEvtQ};
    end else begin : g_full
      assign intEvt  = intEvtQ;
      assign intEvt2 = intEvt2Q;
      assign expEvt  = expEvtQ;
    end
  endgenerate
endmodule

// File: rtl/exc_entry_top.sv
module exc_entry_top
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int EVT_W = 12,
  parameter int BL_BIT = 28,
  parameter int RB_BIT = 29,
  parameter int MD_BIT = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  input  logic             intReq,
  input  logic [EVT_W-1:0] intCode,
  input  logic             excReq,
  input  logic [EVT_W-1:0] excCode,
  input  logic             excTlbMiss,
  input  logic [XLEN-1:0]  curPc,
  input  logic [XLEN-1:0]  curSr,
  input  logic [XLEN-1:0]  vecBase,
  output logic [XLEN-1:0]  savedPc,
  output logic [XLEN-1:0]  savedSr,
  output logic [XLEN-1:0]  newSr,
  output logic [XLEN-1:0]  intEvt,
  output logic [XLEN-1:0]  intEvt2,
  output logic [XLEN-1:0]  expEvt,
  output logic             redirect,
  output logic [XLEN-1:0]  target
);
  entryCtl_t ctl;

  exc_entry_ctrl u_ctrl (
    .boundary  (boundary),
    .intReq    (intReq),
    .excReq    (excReq),
    .excTlbMiss(excTlbMiss),
    .blockNow  (curSr[BL_BIT]),
    .ctl       (ctl)
  );

  exc_entry_dp #(
    .XLEN(XLEN), .EVT_W(EVT_W),
    .BL_BIT(BL_BIT), .RB_BIT(RB_BIT), .MD_BIT(MD_BIT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .intCode (intCode),
    .excCode (excCode),
    .curPc   (curPc),
    .curSr   (curSr),
    .vecBase (vecBase),
    .savedPc (savedPc),
    .savedSr (savedSr),
    .newSr   (newSr),
    .intEvt  (intEvt),
    .intEvt2 (intEvt2),
    .expEvt  (expEvt),
    .redirect(redirect),
    .target  (target)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 32,
  parameter int EVT_W = 12,
  parameter int BL_BIT = 28,
  parameter int RB_BIT = 29,
  parameter int MD_BIT = 30
) (
  input logic             clk,
  input logic             rst,
  input logic             boundary,
  input logic             intReq,
  input logic [EVT_W-1:0] intCode,
  input logic             excReq,
  input logic [EVT_W-1:0] excCode,
  input logic             excTlbMiss,
  input logic [XLEN-1:0]  curPc,
  input logic [XLEN-1:0]  curSr,
  input logic [XLEN-1:0]  vecBase,
  input logic [XLEN-1:0]  savedPc,
  input logic [XLEN-1:0]  savedSr,
  input logic [XLEN-1:0]  newSr,
  input logic [XLEN-1:0]  intEvt,
  input logic [XLEN-1:0]  intEvt2,
  input logic [XLEN-1:0]  expEvt,
  input logic             redirect,
  input logic [XLEN-1:0]  target
);
  logic accept;
  assign accept = boundary && (excReq || (intReq && !curSr[BL_BIT]));

  AST_NO_BOUNDARY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> !redirect && $stable(savedPc) && $stable(expEvt)); // R1
  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    accept |=> savedPc == $past(curPc) && savedSr == $past(curSr)); // R2
  AST_SR_BITS: assert property (@(posedge clk) disable iff (rst)
    redirect |-> newSr[BL_BIT] && newSr[RB_BIT] && newSr[MD_BIT]); // R3
  AST_INT_CODE: assert property (@(posedge clk) disable iff (rst)
    (boundary && intReq && !excReq && !curSr[BL_BIT]) |=>
      intEvt[EVT_W-1:0] == $past(intCode) && intEvt2 == intEvt); // R4
  AST_EVT_UPPER: assert property (@(posedge clk) disable iff (rst)
    intEvt[XLEN-1:EVT_W] == '0 && intEvt2[XLEN-1:EVT_W] == '0
      && expEvt[XLEN-1:EVT_W] == '0); // R4
  AST_EXC_KEEPS_INT: assert property (@(posedge clk) disable iff (rst)
    (boundary && excReq) |=> $stable(intEvt) && $stable(intEvt2)); // R5
  AST_TLB_TARGET: assert property (@(posedge clk) disable iff (rst)
    (boundary && excReq && excTlbMiss) |=>
      redirect && target == $past(vecBase) + 32'h400); // R6
  AST_BL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (boundary && intReq && !excReq && curSr[BL_BIT]) |=>
      !redirect && $stable(intEvt) && $stable(savedPc)); // R7
  AST_EXC_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (boundary && excReq && intReq) |=>
      expEvt[EVT_W-1:0] == $past(excCode)); // R8
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !redirect); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !redirect && savedPc == '0 && expEvt == '0 && intEvt == '0); // R10
endmodule

bind exc_entry_top exc_entry_chk #(
  .XLEN(XLEN), .EVT_W(EVT_W),
  .BL_BIT(BL_BIT), .RB_BIT(RB_BIT), .MD_BIT(MD_BIT)
) u_chk (.*);

// File: tb/tb_exc_entry_top.sv
module tb_exc_entry_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        boundary, intReq, excReq, excTlbMiss;
  logic [11:0] intCode, excCode;
  logic [31:0] curPc, curSr, vecBase;
  logic [31:0] savedPc, savedSr, newSr, intEvt, intEvt2, expEvt, target;
  logic        redirect;

  int nChecks = 0;
  int nFails = 0;

  logic [31:0] eSavedPc, eSavedSr, eNewSr, eIntEvt, eExpEvt, eTarget;
  logic        eRedirect;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_top dut (
    .clk(clk), .rst(rst), .boundary(boundary), .intReq(intReq),
    .intCode(intCode), .excReq(excReq), .excCode(excCode),
    .excTlbMiss(excTlbMiss), .curPc(curPc), .curSr(curSr),
    .vecBase(vecBase), .savedPc(savedPc), .savedSr(savedSr),
    .newSr(newSr), .intEvt(intEvt), .intEvt2(intEvt2), .expEvt(expEvt),
    .redirect(redirect), .target(target)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " redirect"}, {31'b0, redirect}, {31'b0, eRedirect});
    check({tag, " savedPc"}, savedPc, eSavedPc);
    check({tag, " savedSr"}, savedSr, eSavedSr);
    check({tag, " newSr"}, newSr, eNewSr);
    check({tag, " intEvt"}, intEvt, eIntEvt);
    check({tag, " intEvt2"}, intEvt2, eIntEvt);
    check({tag, " expEvt"}, expEvt, eExpEvt);
    check({tag, " target"}, target, eTarget);
  endtask

  task automatic clearModel();
    eSavedPc = 0; eSavedSr = 0; eNewSr = 0; eIntEvt = 0;
    eExpEvt = 0; eTarget = 0; eRedirect = 0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    clearModel();
    checkAll("R10 reset");
  endtask

  // Model: R1, R2, R3, R4, R5, R6, R7, R8, R9, R11
  task automatic applyStep(input logic b, input logic ir, input logic er,
                           input logic tm, input logic bl,
                           input logic [31:0] pc, input logic [31:0] vb,
                           input logic [11:0] ic, input logic [11:0] ec);
    logic takeExc, takeInt;
    logic [31:0] sr;
    sr = {pc[7:0], pc[31:24], pc[15:8], pc[23:16]};
    sr[28] = bl;
    boundary = b; intReq = ir; excReq = er; excTlbMiss = tm;
    curPc = pc; curSr = sr; vecBase = vb; intCode = ic; excCode = ec;
    takeExc = b && er;
    takeInt = b && ir && !er && !bl;
    eRedirect = takeExc || takeInt;
    if (eRedirect) begin
      eSavedPc = pc;
      eSavedSr = sr;
      eNewSr = sr | 32'h7000_0000;
      if (takeInt) begin
        eIntEvt = {20'b0, ic};
        eTarget = vb + 32'h600;
      end else begin
        eExpEvt = {20'b0, ec};
        eTarget = vb + (tm ? 32'h400 : 32'h100);
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (!b) checkAll("R1 idle");
    else if (er && ir) checkAll("R8 priority");
    else if (ir && bl) checkAll("R7 blocked");
    else if (er) checkAll(tm ? "R6 tlbmiss" : "R5 exception");
    else if (ir) checkAll("R4 interrupt");
    else checkAll("R9 no request");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nChecks, -1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] bases [4];
    bases[0] = 32'h0000_0000;
    bases[1] = 32'h8C00_0000;
    bases[2] = 32'hFFFF_FF00;   // R11 wraps for every offset
    bases[3] = 32'hFFFF_FC80;   // R11 wraps only for the larger offsets
    boundary = 0; intReq = 0; excReq = 0; excTlbMiss = 0;
    intCode = 0; excCode = 0; curPc = 0; curSr = 0; vecBase = 0;
    clearModel();
    @(negedge clk);
    doReset();
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 32; c++) begin
        logic [31:0] pc;
        pc = 32'h1357_9BDF * (p * 32 + c + 1);
        applyStep(c[0], c[1], c[2], c[3], c[4], pc, bases[p % 4],
                  12'(12'h5A0 + p * 37 + c), 12'(12'h0C3 ^ (c * 19 + p)));
      end
      if (p == 3) doReset();
    end
    // R9: back-to-back acceptances keep redirect high, then it drops
    applyStep(1, 1, 0, 0, 0, 32'hA000_0004, 32'h0000_1000, 12'h400, 12'h000);
    applyStep(1, 0, 1, 1, 1, 32'hA000_0008, 32'h0000_2000, 12'h000, 12'h040);
    applyStep(0, 1, 1, 0, 0, 32'hA000_000C, 32'h0000_3000, 12'h7FF, 12'hFFF);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule